// File: doc/BRIEF.md
# Command-Stream I2C Master Sequencer

This block runs an I2C bus as its only master. Software, or a register front end, fills a transmit FIFO with 10-bit command words. The sequencer pops each word and turns it into bus activity. A word holds a byte, plus two flags: one asks for a START before the byte, the other asks for a STOP after it. A START-flagged byte is a slave address. When its lowest bit (R/W) is 1, the word that follows is a byte count rather than data. The sequencer then clocks in that many bytes and hands each one to a receive FIFO.

Any acknowledge failure or lost arbitration raises a one-cycle event and freezes the command stream until a flush. A separate line monitor follows the synchronised wires and reports the bus as busy from any START to the next STOP. It pulses an event when the bus falls idle. SCL timing uses a quarter-bit tick derived from the system clock by the `DIV` parameter. The SCL and SDA outputs are open-drain enables: 1 pulls the line low, 0 releases it.

Top module: `dyn_i2c_master`

## Requirements
- R1: After reset both line enables are 0, `bus_busy_o` is 0 and `cmd_ready_o` is 1.
- R2: A word with bit 8 set sends START, then bits 7:0 as the address, MSB first, and samples the slave ACK. A word with bit 8 clear, issued while the bus is owned, sends bits 7:0 as data. Bit 9 set on a written byte issues STOP after its ACK.
- R3: A single word with both bit 8 and bit 9 set and a write address performs an address-only transaction: START, address, ACK, STOP.
- R4: After an acknowledged address with bit 0 = 1, the next word's bits 7:0 give the read length. Each received byte appears on `rx_data_o` with a one-cycle `rx_valid_o`, in bus order. The master ACKs every byte except the last, which it NACKs. STOP follows the last byte when the count word has bit 9 set.
- R5: The master's NACK on the final read byte pulses `ev_nack_o` once, and the sequencer keeps accepting commands.
- R6: A START-flagged word that arrives while the bus is still owned produces a repeated START with no STOP and no bus-idle event before it.
- R7: A word without bit 8, popped while the bus is free, is discarded and causes no bus activity.
- R8: A slave NACK on an address or written byte pulses `ev_nack_o`, issues STOP, and holds `cmd_ready_o` at 0 until `flush_i`.
- R9: If the master releases SDA for a 1 bit and samples it low, it pulses `ev_arb_lost_o`, releases both lines at once and holds `cmd_ready_o` at 0 until `flush_i`.
- R10: `bus_busy_o` is 1 between a START and a STOP seen on the wires. `ev_bus_idle_o` pulses once per STOP that ends a busy period.
- R11: Inside bytes and acknowledge bits, SDA changes only while SCL is low, so no spurious START or STOP appears on the wire.
- R12: A read count of 255 receives exactly 255 bytes.
- R13: `flush_i` returns the sequencer to idle with both lines released, after which commands run normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Synchronous return to idle, releasing the bus |
| cmd_valid_i | input | 1 | Transmit FIFO has a word |
| cmd_word_i | input | 10 | Command word: byte 7:0, START 8, STOP 9 |
| cmd_ready_o | output | 1 | Word is popped when high with valid |
| rx_valid_o | output | 1 | Received byte strobe |
| rx_data_o | output | 8 | Received byte |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| bus_busy_o | output | 1 | Bus owned by some master |
| ev_nack_o | output | 1 | Acknowledge error or final-read NACK pulse |
| ev_arb_lost_o | output | 1 | Arbitration lost pulse |
| ev_bus_idle_o | output | 1 | Bus returned to idle pulse |

## Verification
A behavioural slave on the wired-AND lines decodes START, STOP and every byte with its ACK bit on each clock, and compares each one against a token list built from the command words.

Several patterns are used, and each tells a different fault apart:
- Writes, address-only transfers and a mixed write/read with a repeated START separate the framing flags from one another.
- Short reads and a 255-byte read expose errors in the ACK/NACK choice and in the count.
- An unmatched address and a data byte the slave refuses show whether the sequencer halts.
- A second driver pulling SDA during an address 1 bit shows whether both lines are released on arbitration loss.
- A stray data word on a free bus must leave the wires untouched.

// File: rtl/dyn_i2c_pkg.sv
package dyn_i2c_pkg;
  localparam int unsigned CMD_W     = 10;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned START_BIT = 8;
  localparam int unsigned STOP_BIT  = 9;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HOLD, ST_CNT, ST_START, ST_BIT, ST_ACK, ST_STOP, ST_HALT
  } seq_state_e;
endpackage

// File: rtl/dyn_i2c_sync.sv
module dyn_i2c_sync #(
  parameter int unsigned N      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '1;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '1;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dyn_i2c_tick.sv
module dyn_i2c_tick #(
  parameter int unsigned DIV = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)             cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/dyn_i2c_busmon.sv
module dyn_i2c_busmon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic busy_o,
  output logic idle_ev_o
);
  logic scl_p_q, sda_p_q, busy_q, idle_q;
  logic start_det, stop_det;

  assign start_det = scl_p_q & scl_i & sda_p_q & ~sda_i;
  assign stop_det  = scl_p_q & scl_i & ~sda_p_q & sda_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      scl_p_q <= 1'b1;
      sda_p_q <= 1'b1;
      busy_q  <= 1'b0;
      idle_q  <= 1'b0;
    end else begin
      scl_p_q <= scl_i;
      sda_p_q <= sda_i;
      idle_q  <= stop_det & busy_q;
      if (start_det)     busy_q <= 1'b1;
      else if (stop_det) busy_q <= 1'b0;
    end

  assign busy_o    = busy_q;
  assign idle_ev_o = idle_q;

  a_r10_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> busy_o);
  a_r10_idle_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_ev_o |-> !busy_o);
endmodule

// File: rtl/dyn_i2c_master.sv
module dyn_i2c_master
  import dyn_i2c_pkg::*;
#(
  parameter int unsigned DIV         = 125,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              cmd_valid_i,
  input  logic [CMD_W-1:0]  cmd_word_i,
  output logic              cmd_ready_o,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_data_o,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic              bus_busy_o,
  output logic              ev_nack_o,
  output logic              ev_arb_lost_o,
  output logic              ev_bus_idle_o
);
  localparam logic [2:0] MSB_IDX = 3'(BYTE_W - 1);

  logic scl_s, sda_s, tick;

  dyn_i2c_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i({scl_i, sda_i}), .q_o({scl_s, sda_s}));

  dyn_i2c_tick #(.DIV(DIV)) u_tick (.clk_i, .rst_ni, .tick_o(tick));

  dyn_i2c_busmon u_mon (
    .clk_i, .rst_ni, .scl_i(scl_s), .sda_i(sda_s),
    .busy_o(bus_busy_o), .idle_ev_o(ev_bus_idle_o));

  seq_state_e        state_q;
  logic [1:0]        ph_q;
  logic [2:0]        bit_q;
  logic [BYTE_W-1:0] sh_q, left_q;
  logic rd_q, addr_q, stop_q, fail_q;
  logic scl_oe_q, sda_oe_q, rx_v_q, nack_q, arb_q;
  logic pop, xfer_rd, last_rx, step;

  assign cmd_ready_o = state_q inside {ST_IDLE, ST_HOLD, ST_CNT};
  assign pop         = cmd_valid_i & cmd_ready_o;
  assign xfer_rd     = rd_q & ~addr_q;
  assign last_rx     = (left_q == BYTE_W'(1));
  // phase 2 acts only once SCL is really high (clock stretching)
  assign step        = tick & ((ph_q != 2'd2) | scl_s);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q <= ST_IDLE;  ph_q <= '0;  bit_q <= '0;
      sh_q <= '0;  left_q <= '0;
      rd_q <= 1'b0;  addr_q <= 1'b0;  stop_q <= 1'b0;  fail_q <= 1'b0;
      scl_oe_q <= 1'b0;  sda_oe_q <= 1'b0;
      rx_v_q <= 1'b0;  nack_q <= 1'b0;  arb_q <= 1'b0;
    end else begin
      rx_v_q <= 1'b0;
      nack_q <= 1'b0;
      arb_q  <= 1'b0;
      if (flush_i) begin
        state_q <= ST_IDLE;  ph_q <= '0;  fail_q <= 1'b0;
        scl_oe_q <= 1'b0;  sda_oe_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE, ST_HOLD: if (pop) begin
            sh_q   <= cmd_word_i[BYTE_W-1:0];
            stop_q <= cmd_word_i[STOP_BIT];
            ph_q   <= '0;
            bit_q  <= MSB_IDX;
            if (cmd_word_i[START_BIT]) begin
              rd_q <= cmd_word_i[0];  addr_q <= 1'b1;  state_q <= ST_START;
            end else if (state_q == ST_HOLD) begin
              rd_q <= 1'b0;  addr_q <= 1'b0;  state_q <= ST_BIT;
            end
          end
          ST_CNT: if (pop) begin
            left_q <= cmd_word_i[BYTE_W-1:0];
            stop_q <= cmd_word_i[STOP_BIT];
            addr_q <= 1'b0;  ph_q <= '0;  bit_q <= MSB_IDX;
            if (cmd_word_i[BYTE_W-1:0] == '0)
              state_q <= cmd_word_i[STOP_BIT] ? ST_STOP : ST_HOLD;
            else
              state_q <= ST_BIT;
          end
          ST_START: if (step) begin
            ph_q <= ph_q + 2'd1;
            unique case (ph_q)
              2'd0: sda_oe_q <= 1'b0;
              2'd1: scl_oe_q <= 1'b0;
              2'd2: sda_oe_q <= 1'b1;
              default: begin scl_oe_q <= 1'b1;  state_q <= ST_BIT;  bit_q <= MSB_IDX; end
            endcase
          end
          ST_BIT: if (step) begin
            ph_q <= ph_q + 2'd1;
            unique case (ph_q)
              2'd0: sda_oe_q <= xfer_rd ? 1'b0 : ~sh_q[BYTE_W-1];
              2'd1: scl_oe_q <= 1'b0;
              2'd2: begin
                if (!xfer_rd && sh_q[BYTE_W-1] && !sda_s) begin
                  arb_q <= 1'b1;  scl_oe_q <= 1'b0;  sda_oe_q <= 1'b0;
                  state_q <= ST_HALT;
                end
                sh_q <= {sh_q[BYTE_W-2:0], sda_s};
              end
              default: begin
                scl_oe_q <= 1'b1;
                if (bit_q == '0) state_q <= ST_ACK;
                else             bit_q <= bit_q - 3'd1;
              end
            endcase
          end
          ST_ACK: if (step) begin
            ph_q <= ph_q + 2'd1;
            unique case (ph_q)
              2'd0: sda_oe_q <= xfer_rd & ~last_rx;
              2'd1: scl_oe_q <= 1'b0;
              2'd2: if (xfer_rd) begin
                rx_v_q <= 1'b1;  nack_q <= last_rx;
              end else if (sda_s) begin
                nack_q <= 1'b1;  fail_q <= 1'b1;
              end
              default: begin
                scl_oe_q <= 1'b1;
                if (xfer_rd) begin
                  left_q <= left_q - BYTE_W'(1);
                  if (last_rx) state_q <= stop_q ? ST_STOP : ST_HOLD;
                  else begin state_q <= ST_BIT;  bit_q <= MSB_IDX; end
                end else if (fail_q)        state_q <= ST_STOP;
                else if (addr_q && rd_q)    state_q <= ST_CNT;
                else                        state_q <= stop_q ? ST_STOP : ST_HOLD;
              end
            endcase
          end
          ST_STOP: if (step) begin
            ph_q <= ph_q + 2'd1;
            unique case (ph_q)
              2'd0: sda_oe_q <= 1'b1;
              2'd1: scl_oe_q <= 1'b0;
              2'd2: sda_oe_q <= 1'b0;
              default: state_q <= fail_q ? ST_HALT : ST_IDLE;
            endcase
          end
          default: ;
        endcase
      end
    end

  assign scl_oe_o      = scl_oe_q;
  assign sda_oe_o      = sda_oe_q;
  assign rx_valid_o    = rx_v_q;
  assign rx_data_o     = sh_q;
  assign ev_nack_o     = nack_q;
  assign ev_arb_lost_o = arb_q;

  a_r11_sda_steady_scl_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q inside {ST_BIT, ST_ACK} && !scl_oe_q) |=>
      (!(state_q inside {ST_BIT, ST_ACK}) || $stable(sda_oe_q)));
  a_r9_release_on_arb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_arb_lost_o |-> (!scl_oe_o && !sda_oe_o));
  a_r9_halt_on_arb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_arb_lost_o && !flush_i) |-> !cmd_ready_o);
  a_r4_count_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BIT && xfer_rd) |-> (left_q != '0));
endmodule

// File: tb/dyn_i2c_master_bench.sv
module dyn_i2c_master_bench;
  localparam int DIV = 5;
  localparam int TOK_S = 'h1000;
  localparam int TOK_P = 'h2000;
  localparam logic [6:0] SLV_ADDR = 7'h2A;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic cmd_valid = 1'b0;
  logic [9:0] cmd_word = '0;
  logic cmd_ready, rx_valid, scl_oe, sda_oe, busy, ev_nack, ev_arb, ev_idle;
  logic [7:0] rx_data;
  logic slv_oe = 1'b0, arb_oe = 1'b0, arb_on = 1'b0;
  logic scl_w, sda_w;

  always #2 clk = ~clk;

  assign scl_w = ~scl_oe;
  assign sda_w = ~(sda_oe | slv_oe | arb_oe);

  dyn_i2c_master #(.DIV(DIV)) u_dyn_i2c_master (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .cmd_valid_i(cmd_valid), .cmd_word_i(cmd_word), .cmd_ready_o(cmd_ready),
    .rx_valid_o(rx_valid), .rx_data_o(rx_data),
    .scl_i(scl_w), .sda_i(sda_w), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
    .bus_busy_o(busy), .ev_nack_o(ev_nack), .ev_arb_lost_o(ev_arb),
    .ev_bus_idle_o(ev_idle));

  int n_chk = 0, n_fail = 0;
  int n_nack = 0, n_arb = 0, n_idle = 0, tok_cnt = 0, spurious = 0;
  int exp_q[$];
  int exp_rx[$];
  string cur_req = "R1";
  int ack_limit = 99;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic got(input int tok);
    int e;
    tok_cnt++;
    if (exp_q.size() == 0) begin
      chk(1'b0, cur_req, tok, -1);
      if (tok >= TOK_S) spurious++;
    end else begin
      e = exp_q.pop_front();
      if (tok != e && tok >= TOK_S) spurious++;
      chk(tok == e, cur_req, tok, e);
    end
  endtask

  // behavioural slave and wire decoder, evaluated every clock
  logic p_scl = 1'b1, p_sda = 1'b1, first = 1'b0, rd_dir = 1'b0;
  logic [7:0] sh = '0, rd_byte = '0;
  int bit_i = 0, wr_cnt = 0;

  always @(negedge clk) begin
    if (!arb_on) arb_oe = 1'b0;
    if (rst_n) begin
      if (p_scl && scl_w && p_sda && !sda_w) begin
        got(TOK_S); bit_i = 0; first = 1'b1; rd_dir = 1'b0; slv_oe = 1'b0; wr_cnt = 0;
      end else if (p_scl && scl_w && !p_sda && sda_w) begin
        got(TOK_P); slv_oe = 1'b0; rd_dir = 1'b0;
      end else if (!p_scl && scl_w) begin
        if (bit_i < 8) begin
          sh = {sh[6:0], sda_w}; bit_i++;
        end else begin
          got({23'd0, sda_w, sh});
          if (first) begin
            rd_dir = sh[0] && !sda_w; rd_byte = 8'hA0; first = 1'b0;
          end else if (rd_dir) begin
            rd_byte++;
            if (sda_w) rd_dir = 1'b0;
          end else wr_cnt++;
          bit_i = 9;
        end
      end else if (p_scl && !scl_w) begin
        if (bit_i == 9) bit_i = 0;
        if (bit_i == 8)
          slv_oe = !rd_dir && ((first && sh[7:1] == SLV_ADDR) || (!first && wr_cnt < ack_limit));
        else if (rd_dir) slv_oe = ~rd_byte[7 - bit_i];
        else slv_oe = 1'b0;
        if (arb_on && bit_i == 1) arb_oe = 1'b1;
      end
    end
    p_scl = scl_w;
    p_sda = sda_w;
  end

  always @(negedge clk) if (rst_n) begin
    if (ev_nack) n_nack++;
    if (ev_arb)  n_arb++;
    if (ev_idle) n_idle++;
    if (rx_valid) begin
      if (exp_rx.size() == 0) chk(1'b0, "R4", rx_data, -1);
      else begin
        int e;
        e = exp_rx.pop_front();
        chk(rx_data == e[7:0], "R4", rx_data, e);
      end
    end
  end

  task automatic send(input logic [9:0] w);
    cmd_valid = 1'b1; cmd_word = w;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic expb(input int v, input bit nak);
    exp_q.push_back({nak, v[7:0]});
  endtask

  task automatic wait_done;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (30) @(negedge clk);
  endtask

  task automatic do_flush;
    flush = 1'b1; @(negedge clk); flush = 1'b0; @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int idle0, nack0, t0, rdy;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!scl_oe && !sda_oe, "R1", {scl_oe, sda_oe}, 0);
    chk(!busy, "R1", busy, 0);
    chk(cmd_ready, "R1", cmd_ready, 1);

    // R2 plain write with STOP on last byte
    cur_req = "R2"; idle0 = n_idle;
    exp_q.push_back(TOK_S); expb('h54, 0); expb('h11, 0); expb('h22, 0); exp_q.push_back(TOK_P);
    send(10'h154); send(10'h011); send(10'h222);
    wait_done;
    chk(exp_q.size() == 0, "R2", exp_q.size(), 0);
    chk(n_idle == idle0 + 1, "R10", n_idle - idle0, 1);
    chk(!busy, "R10", busy, 0);

    // R3 address-only, busy while on the bus
    cur_req = "R3";
    exp_q.push_back(TOK_S); expb('h54, 0); exp_q.push_back(TOK_P);
    send(10'h354);
    repeat (40) @(negedge clk);
    chk(busy, "R10", busy, 1);
    wait_done;
    chk(!busy && n_idle == idle0 + 2, "R3", n_idle - idle0, 2);

    // R4 / R5 read three bytes with STOP
    cur_req = "R4"; nack0 = n_nack;
    exp_q.push_back(TOK_S); expb('h55, 0);
    expb('hA0, 0); expb('hA1, 0); expb('hA2, 1); exp_q.push_back(TOK_P);
    exp_rx.push_back('hA0); exp_rx.push_back('hA1); exp_rx.push_back('hA2);
    send(10'h155); send(10'h203);
    wait_done;
    chk(exp_rx.size() == 0, "R4", exp_rx.size(), 0);
    chk(n_nack == nack0 + 1, "R5", n_nack - nack0, 1);
    chk(cmd_ready, "R5", cmd_ready, 1);

    // R6 write then repeated START into a one-byte read
    cur_req = "R6"; idle0 = n_idle;
    exp_q.push_back(TOK_S); expb('h54, 0); expb('h33, 0);
    exp_q.push_back(TOK_S); expb('h55, 0); expb('hA0, 1); exp_q.push_back(TOK_P);
    exp_rx.push_back('hA0);
    send(10'h154); send(10'h033); send(10'h155); send(10'h201);
    wait_done;
    chk(n_idle == idle0 + 1, "R6", n_idle - idle0, 1);

    // R7 data word on a free bus is dropped
    cur_req = "R7"; t0 = tok_cnt;
    send(10'h077);
    repeat (200) @(negedge clk);
    chk(tok_cnt == t0 && !busy && !sda_oe && !scl_oe, "R7", tok_cnt - t0, 0);

    // R8 address NACK, then halted
    cur_req = "R8"; nack0 = n_nack;
    exp_q.push_back(TOK_S); expb('h60, 1); exp_q.push_back(TOK_P);
    send(10'h360);
    wait_done;
    chk(n_nack == nack0 + 1, "R8", n_nack - nack0, 1);
    t0 = tok_cnt; rdy = 0;
    cmd_valid = 1'b1; cmd_word = 10'h354;
    repeat (300) begin @(negedge clk); if (cmd_ready) rdy++; end
    cmd_valid = 1'b0;
    chk(rdy == 0 && tok_cnt == t0, "R8", rdy, 0);
    do_flush;
    chk(cmd_ready && !scl_oe && !sda_oe, "R13", cmd_ready, 1);
    cur_req = "R13";
    exp_q.push_back(TOK_S); expb('h54, 0); exp_q.push_back(TOK_P);
    send(10'h354);
    wait_done;
    chk(exp_q.size() == 0, "R13", exp_q.size(), 0);

    // R8 data byte NACK
    cur_req = "R8"; nack0 = n_nack; ack_limit = 1;
    exp_q.push_back(TOK_S); expb('h54, 0); expb('hAA, 0); expb('hBB, 1); exp_q.push_back(TOK_P);
    send(10'h154); send(10'h0AA); send(10'h2BB);
    wait_done;
    chk(n_nack == nack0 + 1 && !cmd_ready, "R8", n_nack - nack0, 1);
    ack_limit = 99;
    do_flush;

    // R9 arbitration loss on address bit 6
    cur_req = "R9"; idle0 = n_idle;
    exp_q.push_back(TOK_S);
    arb_on = 1'b1;
    send(10'h154);
    t0 = 0;
    while (n_arb == 0 && t0 < 2000) begin @(negedge clk); t0++; end
    chk(n_arb == 1, "R9", n_arb, 1);
    chk(!scl_oe && !sda_oe && !cmd_ready, "R9", {scl_oe, sda_oe, cmd_ready}, 0);
    exp_q.push_back(TOK_P);
    arb_on = 1'b0;
    wait_done;
    chk(n_idle == idle0 + 1 && !busy, "R10", n_idle - idle0, 1);
    chk(!cmd_ready, "R9", cmd_ready, 0);
    do_flush;

    // R12 maximum read length
    cur_req = "R12";
    exp_q.push_back(TOK_S); expb('h55, 0);
    for (int k = 0; k < 255; k++) begin
      expb(8'(8'hA0 + k), k == 254);
      exp_rx.push_back(8'(8'hA0 + k));
    end
    exp_q.push_back(TOK_P);
    send(10'h155); send(10'h2FF);
    wait_done;
    chk(exp_rx.size() == 0 && exp_q.size() == 0, "R12", exp_rx.size(), 0);

    // R11 no spurious START or STOP on the wire at any time
    chk(spurious == 0, "R11", spurious, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule